// File: doc/BRIEF.md
# Oversampled Position Capture Buffer

This block takes several snapshots of a free-running 32-bit position counter within each bus cycle, rather than a single read per cycle. Every fast sample pulse stores the present counter value in the next free slot of a fill bank. When the slow cycle pulse arrives, that bank becomes the published packet. The block also latches the 64-bit time of the coming cycle pulse, so the host can relate the packet to the time base. A second bank takes the new cycle's samples while the host reads the published one through an indexed read port.

The configured factor n sets how many samples make up a full cycle. It may range from 1 to 100. If the configuration flag is low, or n is outside that range, the block withholds its process data. Short cycles are still published with the number of samples actually taken, and they raise a sticky underrun flag. The counter itself, the pulse generation and the fieldbus transfer lie outside the block.

Top module: `ovs_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, `pkt_valid_o` and `underrun_o` are 0, `pkt_count_o` is 0 and `rd_data_o` is 0.
- R2: In a valid cycle, the k-th accepted fast pulse (k counted from 0) stores `pos_i` in slot k. After publication, `rd_idx_i` = k returns that value.
- R3: A packet is published at the clock edge that samples `cycle_pulse_i` high and is visible right after that edge. Valid, count, timestamp and sample contents then hold until the next cycle pulse, even while new samples are being taken.
- R4: `pkt_ts_o` takes the value of `next_ts_i` at every cycle-pulse edge.
- R5: The configuration is good when `cfg_ok_i` is 1 and 1 <= `factor_i` <= 100. A cycle that closes with a bad configuration publishes `pkt_valid_o` = 0 and `pkt_count_o` = 0, and `rd_data_o` reads 0.
- R6: Fast pulses after n samples have been taken in a cycle are ignored. The count never exceeds n, and slots 0..n-1 keep the first n values.
- R7: A good cycle that closes with fewer than n samples publishes the number actually taken and sets `underrun_o`. The flag then stays 1 until reset.
- R8: When a fast pulse and a cycle pulse meet on one edge, the sample is stored as the last entry of the closing packet, and then the banks swap.
- R9: The first cycle pulse after reset only starts the first cycle. It publishes `pkt_valid_o` = 0 and does not set `underrun_o`.
- R10: For `rd_idx_i` >= `pkt_count_o`, `rd_data_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_i | input | SMP_W | Running position counter value |
| fast_pulse_i | input | 1 | One-cycle sample strobe |
| cycle_pulse_i | input | 1 | One-cycle bus-cycle strobe |
| factor_i | input | IDX_W | Samples per cycle, n |
| cfg_ok_i | input | 1 | Configuration accepted by the host |
| next_ts_i | input | TS_W | Time of the coming cycle pulse |
| rd_idx_i | input | IDX_W | Slot to read from the published packet |
| rd_data_o | output | SMP_W | Sample in slot `rd_idx_i`, 0 if absent |
| pkt_valid_o | output | 1 | Published packet holds process data |
| pkt_count_o | output | IDX_W | Samples in the published packet |
| pkt_ts_o | output | TS_W | Timestamp of the published packet |
| underrun_o | output | 1 | Sticky: some good cycle closed short |

## Verification
Each sample lands in its bank at the edge that sees its fast pulse. Valid, count, timestamp and underrun all change at the single edge that sees the cycle pulse, and the read port is combinational from those registers. The driver raises pulses on falling edges and queues the expected packet before the cycle-pulse edge. The monitor pops that packet one falling edge later, which is the first settled point after publication, and sweeps the read index in small steps within that low phase. On the falling edge where the next cycle pulse has just been raised, the monitor reads the previous packet again. That check shows it stayed intact while the other bank was filling.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int DEF_SMP_W = 32;
    localparam int DEF_TS_W  = 64;
    localparam int DEF_MAX_N = 100;

    // Per-clock control decoded by the index stage.
    typedef struct packed {
        logic take;      // this fast pulse is stored
        logic close;     // cycle pulse ends the packet
        logic cfg_good;  // configuration usable this edge
    } cyc_ctl_t;

    function automatic logic factor_usable(input logic ok,
                                           input int unsigned f,
                                           input int unsigned max_n);
        return ok && (f != 0) && (f <= max_n);
    endfunction

endpackage

// File: rtl/ovs_index_ctrl.sv
module ovs_index_ctrl
    import ovs_pkg::*;
#(
    parameter int MAX_N = DEF_MAX_N,
    parameter int IDX_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast_pulse_i,
    input  logic             cycle_pulse_i,
    input  logic [IDX_W-1:0] factor_i,
    input  logic             cfg_ok_i,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             fill_sel_o,
    output logic [IDX_W-1:0] cnt_now_o,
    output cyc_ctl_t         ctl_o
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_N);

    logic [IDX_W-1:0] wr_idx_q;
    logic             fill_sel_q;
    logic             take;

    assign take = fast_pulse_i && (wr_idx_q < factor_i) && (wr_idx_q < LIMIT);

    // Count including a sample taken on this very edge (same-edge ordering).
    assign cnt_now_o = wr_idx_q + IDX_W'(take);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx_q   <= '0;
            fill_sel_q <= 1'b0;
        end else if (cycle_pulse_i) begin
            wr_idx_q   <= '0;
            fill_sel_q <= ~fill_sel_q;
        end else if (take) begin
            wr_idx_q   <= wr_idx_q + 1'b1;
        end
    end

    always_comb begin
        ctl_o.take     = take;
        ctl_o.close    = cycle_pulse_i;
        ctl_o.cfg_good = factor_usable(cfg_ok_i, 32'(factor_i), MAX_N);
    end

    assign wr_idx_o   = wr_idx_q;
    assign fill_sel_o = fill_sel_q;
endmodule

// File: rtl/ovs_bank_pair.sv
module ovs_bank_pair #(
    parameter int SMP_W = 32,
    parameter int MAX_N = 100,
    parameter int IDX_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic             wr_sel_i,
    input  logic [IDX_W-1:0] wr_addr_i,
    input  logic [SMP_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic [SMP_W-1:0] rd_data_o
);
    localparam int NBANK = 2;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_N);

    logic [SMP_W-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [SMP_W-1:0] mem [MAX_N];

        always_ff @(posedge clk) begin
            if (we_i && (wr_sel_i == 1'(b)) && (wr_addr_i < LIMIT))
                mem[wr_addr_i] <= wr_data_i;
        end

        assign bank_rd[b] = (rd_addr_i < LIMIT) ? mem[rd_addr_i] : '0;
    end

    // The bank not being filled is the published one.
    assign rd_data_o = bank_rd[~wr_sel_i];
endmodule

// File: rtl/ovs_publish.sv
module ovs_publish
    import ovs_pkg::*;
#(
    parameter int MAX_N = DEF_MAX_N,
    parameter int TS_W  = DEF_TS_W,
    parameter int IDX_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_ctl_t         ctl_i,
    input  logic [IDX_W-1:0] cnt_now_i,
    input  logic [IDX_W-1:0] factor_i,
    input  logic [TS_W-1:0]  next_ts_i,
    output logic             pkt_valid_o,
    output logic [IDX_W-1:0] pkt_count_o,
    output logic [TS_W-1:0]  pkt_ts_o,
    output logic             underrun_o
);
    logic armed_q;
    logic publish;

    assign publish = ctl_i.close && armed_q && ctl_i.cfg_good;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q     <= 1'b0;
            pkt_valid_o <= 1'b0;
            pkt_count_o <= '0;
            pkt_ts_o    <= '0;
            underrun_o  <= 1'b0;
        end else if (ctl_i.close) begin
            armed_q     <= 1'b1;
            pkt_ts_o    <= next_ts_i;
            pkt_valid_o <= publish;
            pkt_count_o <= publish ? cnt_now_i : '0;
            if (publish && (cnt_now_i < factor_i))
                underrun_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ovs_capture.sv
module ovs_capture
    import ovs_pkg::*;
#(
    parameter int   SMP_W = DEF_SMP_W,
    parameter int   TS_W  = DEF_TS_W,
    parameter int   MAX_N = DEF_MAX_N,
    localparam int  IDX_W = $clog2(MAX_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] pos_i,
    input  logic             fast_pulse_i,
    input  logic             cycle_pulse_i,
    input  logic [IDX_W-1:0] factor_i,
    input  logic             cfg_ok_i,
    input  logic [TS_W-1:0]  next_ts_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [SMP_W-1:0] rd_data_o,
    output logic             pkt_valid_o,
    output logic [IDX_W-1:0] pkt_count_o,
    output logic [TS_W-1:0]  pkt_ts_o,
    output logic             underrun_o
);
    logic [IDX_W-1:0] wr_idx;
    logic             fill_sel;
    logic [IDX_W-1:0] cnt_now;
    cyc_ctl_t         ctl;
    logic [SMP_W-1:0] bank_data;

    ovs_index_ctrl #(.MAX_N(MAX_N), .IDX_W(IDX_W)) u_idx (
        .clk          (clk),
        .rst          (rst),
        .fast_pulse_i (fast_pulse_i),
        .cycle_pulse_i(cycle_pulse_i),
        .factor_i     (factor_i),
        .cfg_ok_i     (cfg_ok_i),
        .wr_idx_o     (wr_idx),
        .fill_sel_o   (fill_sel),
        .cnt_now_o    (cnt_now),
        .ctl_o        (ctl)
    );

    ovs_bank_pair #(.SMP_W(SMP_W), .MAX_N(MAX_N), .IDX_W(IDX_W)) u_banks (
        .clk      (clk),
        .we_i     (ctl.take),
        .wr_sel_i (fill_sel),
        .wr_addr_i(wr_idx),
        .wr_data_i(pos_i),
        .rd_addr_i(rd_idx_i),
        .rd_data_o(bank_data)
    );

    ovs_publish #(.MAX_N(MAX_N), .TS_W(TS_W), .IDX_W(IDX_W)) u_pub (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .cnt_now_i  (cnt_now),
        .factor_i   (factor_i),
        .next_ts_i  (next_ts_i),
        .pkt_valid_o(pkt_valid_o),
        .pkt_count_o(pkt_count_o),
        .pkt_ts_o   (pkt_ts_o),
        .underrun_o (underrun_o)
    );

    // Slots past the count, and any packet without process data, read zero.
    assign rd_data_o = (pkt_valid_o && (rd_idx_i < pkt_count_o)) ? bank_data : '0;
endmodule

// File: rtl/ovs_capture_chk.sv
module ovs_capture_chk #(
    parameter int TS_W  = 64,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cycle_pulse_i,
    input logic             cfg_ok_i,
    input logic [IDX_W-1:0] factor_i,
    input logic [TS_W-1:0]  next_ts_i,
    input logic             pkt_valid_o,
    input logic [IDX_W-1:0] pkt_count_o,
    input logic [TS_W-1:0]  pkt_ts_o,
    input logic             underrun_o
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pkt_valid_o && !underrun_o && pkt_count_o == '0));

    // R3
    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        !cycle_pulse_i |=> ($stable(pkt_valid_o) && $stable(pkt_count_o) && $stable(pkt_ts_o)));

    // R4
    a_r4_ts_capture: assert property (@(posedge clk) disable iff (rst)
        cycle_pulse_i |=> (pkt_ts_o == $past(next_ts_i)));

    // R5
    a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
        (cycle_pulse_i && !cfg_ok_i) |=> (!pkt_valid_o && pkt_count_o == '0));

    // R6
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cycle_pulse_i |=> (pkt_count_o <= $past(factor_i)));

    // R7
    a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> underrun_o);
endmodule

bind ovs_capture ovs_capture_chk #(.TS_W(TS_W), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cycle_pulse_i(cycle_pulse_i),
    .cfg_ok_i     (cfg_ok_i),
    .factor_i     (factor_i),
    .next_ts_i    (next_ts_i),
    .pkt_valid_o  (pkt_valid_o),
    .pkt_count_o  (pkt_count_o),
    .pkt_ts_o     (pkt_ts_o),
    .underrun_o   (underrun_o)
);

// File: tb/ovs_capture_tb_top.sv
module ovs_capture_tb_top;
    localparam int CLK_PERIOD = 400;
    localparam int MAXN = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pos_i = '0;
    logic        fast_pulse_i = 1'b0;
    logic        cycle_pulse_i = 1'b0;
    logic [6:0]  factor_i = 7'd4;
    logic        cfg_ok_i = 1'b1;
    logic [63:0] next_ts_i = '0;
    logic [6:0]  rd_idx_i = '0;
    logic [31:0] rd_data_o;
    logic        pkt_valid_o;
    logic [6:0]  pkt_count_o;
    logic [63:0] pkt_ts_o;
    logic        underrun_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovs_capture dut_i (
        .clk(clk), .rst(rst), .pos_i(pos_i), .fast_pulse_i(fast_pulse_i),
        .cycle_pulse_i(cycle_pulse_i), .factor_i(factor_i), .cfg_ok_i(cfg_ok_i),
        .next_ts_i(next_ts_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
        .pkt_valid_o(pkt_valid_o), .pkt_count_o(pkt_count_o),
        .pkt_ts_o(pkt_ts_o), .underrun_o(underrun_o)
    );

    typedef struct packed {
        logic             valid;
        logic             unr;
        logic [6:0]       cnt;
        logic [63:0]      ts;
        logic [99:0][31:0] s;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    armed_m = 0;
    bit    unr_m   = 0;
    logic [31:0] pos_m = 32'h1000_0000;
    bit    done = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: runs one bus cycle and queues the packet it should produce.
    task automatic run_cycle(input string tag, input int pulses, input int n,
                             input bit ok, input logic [63:0] ts, input bit same_edge);
        exp_t e;
        int   taken;
        bit   good;
        bit   last;
        e = '0;
        taken = 0;
        good = ok && n >= 1 && n <= MAXN;
        @(negedge clk);
        factor_i  = 7'(n);
        cfg_ok_i  = ok;
        next_ts_i = ts;
        for (int k = 0; k < pulses; k++) begin
            last = same_edge && (k == pulses - 1);
            pos_m = pos_m + 32'h0001_0F3B + 32'(k * 7);
            pos_i = pos_m;
            fast_pulse_i = 1'b1;
            if (taken < n && taken < MAXN) begin
                e.s[taken] = pos_m;
                taken++;
            end
            if (last) begin
                cycle_pulse_i = 1'b1;
                e.valid = armed_m && good;
                e.cnt = e.valid ? 7'(taken) : 7'd0;
                if (e.valid && taken < n) unr_m = 1;
                e.unr = unr_m; e.ts = ts; armed_m = 1;
                exp_q.push_back(e); tag_q.push_back(tag);
            end
            @(negedge clk);
            fast_pulse_i = 1'b0;
            cycle_pulse_i = 1'b0;
            if (!last) @(negedge clk);
        end
        if (!same_edge) begin
            e.valid = armed_m && good;
            e.cnt = e.valid ? 7'(taken) : 7'd0;
            if (e.valid && taken < n) unr_m = 1;
            e.unr = unr_m; e.ts = ts; armed_m = 1;
            exp_q.push_back(e); tag_q.push_back(tag);
            cycle_pulse_i = 1'b1;
            @(negedge clk);
            cycle_pulse_i = 1'b0;
        end
    endtask

    // Monitor: checks the previous packet just before a swap, the new one after it.
    initial begin
        exp_t  e;
        exp_t  prev;
        string tg;
        bit    have_prev;
        have_prev = 0;
        prev = '0;
        @(negedge clk);
        wait (!rst);
        forever begin
            @(negedge clk);
            #1;
            if (cycle_pulse_i && exp_q.size() > 0) begin
                if (have_prev) begin
                    chk("R3 hold count", 64'(pkt_count_o), 64'(prev.cnt));
                    chk("R3 hold ts", pkt_ts_o, prev.ts);
                    if (prev.valid && prev.cnt > 0) begin
                        rd_idx_i = 7'd0; #1;
                        chk("R3 hold slot0", 64'(rd_data_o), 64'(prev.s[0]));
                    end
                end
                @(negedge clk);
                #1;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk({tg, " valid"}, 64'(pkt_valid_o), 64'(e.valid));
                chk({tg, " count"}, 64'(pkt_count_o), 64'(e.cnt));
                chk({tg, " R4 ts"}, pkt_ts_o, e.ts);
                chk({tg, " R7 underrun"}, 64'(underrun_o), 64'(e.unr));
                for (int i = 0; i < int'(e.cnt); i++) begin
                    rd_idx_i = 7'(i); #1;
                    chk({tg, " R2 sample"}, 64'(rd_data_o), 64'(e.s[i]));
                end
                if (e.cnt < 7'd100) begin
                    rd_idx_i = e.cnt; #1;
                    chk({tg, " R10 beyond count"}, 64'(rd_data_o), 64'd0);
                end
                if (!e.valid) begin
                    rd_idx_i = 7'd0; #1;
                    chk({tg, " R5 no data"}, 64'(rd_data_o), 64'd0);
                end
                prev = e;
                have_prev = 1;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset valid", 64'(pkt_valid_o), 64'd0);
        chk("R1 reset underrun", 64'(underrun_o), 64'd0);
        chk("R1 reset count", 64'(pkt_count_o), 64'd0);
        chk("R1 reset data", 64'(rd_data_o), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 after release valid", 64'(pkt_valid_o), 64'd0);

        run_cycle("R9 arm",        2,   4, 1, 64'h0000_0001_0000_0000, 0);
        run_cycle("R2 full",       4,   4, 1, 64'h0000_0001_0007_A120, 0);
        run_cycle("R6 excess",     6,   4, 1, 64'h0000_0001_000F_4240, 0);
        run_cycle("R5 cfg low",    4,   4, 0, 64'h0000_0001_0016_E360, 0);
        run_cycle("R5 n zero",     2,   0, 1, 64'h0000_0001_001E_8480, 0);
        run_cycle("R5 n large",    3, 101, 1, 64'h0000_0001_0026_25A0, 0);
        run_cycle("R8 same edge",  5,   5, 1, 64'h0000_0001_002D_C6C0, 1);
        run_cycle("R2 n max",    100, 100, 1, 64'h0000_0001_0035_67E0, 0);
        run_cycle("R7 short",      3,   8, 1, 64'h0000_0001_003D_0900, 0);
        run_cycle("R7 sticky",     4,   4, 1, 64'h0000_0001_0044_AA20, 0);
        run_cycle("R8 short edge", 2,   6, 1, 64'h0000_0001_004C_4B40, 1);

        repeat (4) @(negedge clk);
        chk("R3 queue drained", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule